// File: doc/BRIEF.md
# Fixed Off-Time Mixed-Decay Current Regulator

This block is the per-phase current chopper of a stepper bridge controller. While the phase is enabled it drives the winding until the synchronized current-sense comparator reports that the current has reached its set-point. It then holds the bridge off for a fixed number of clock cycles. On falling steps the off period opens with active (fast) decay and ends with recirculating (slow) decay. A short blanking interval follows, with the bridge driving again, before the comparator is trusted once more.

The translator reports each new step with a strobe and a bit that says whether the new set-point is below the old one. That bit selects mixed or pure slow decay for later off periods. A two-bit select chooses how much of the off period is fast decay. The output is a two-bit bridge request consumed by a separate gate sequencer. All times are counted in cycles of the block clock.

Top module: `mixdecay_cur_reg`

## Requirements
- R1: While reset is asserted, and in the first cycle after it with enable high, the bridge request is all-off (code 00).
- R2: In the drive phase the request is drive (code 01). A comparator trip sampled there makes the next cycle the first off-period cycle.
- R3: The off period lasts exactly OFF_CYC (default 87) cycles, and the comparator has no effect during it.
- R4: In mixed mode the first N off-period cycles are fast decay (code 10) and the rest are slow decay (code 11). N is 0, 15, 48 or 87 for select codes 0, 1, 2 and 3.
- R5: A step strobe with the falling bit low selects pure slow decay: every cycle of later off periods is code 11, for any select code.
- R6: Reset puts the regulator in mixed mode.
- R7: After each off period comes a blanking interval of BLANK_CYC (default 6) cycles with the request at drive (01). A comparator trip in the first BLANK_CYC-1 of those cycles is ignored.
- R8: A trip sampled in the last blanking cycle starts a new off period at once, with no drive phase.
- R9: With enable low the request is 00 in that same cycle and the sequencer returns to idle. After enable rises there is one idle cycle (00), and then the drive phase starts.
- R10: The decay mode and the select code are captured at the trip that starts an off period. Changing either one during that period does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Phase enable; low forces all-off |
| trip_i | input | 1 | Synchronized current-sense comparator output |
| step_upd_i | input | 1 | One-cycle strobe from the translator on each step |
| step_falls_i | input | 1 | With the strobe: new set-point is below the previous one |
| fd_sel_i | input | 2 | Fast-decay fraction select (0, 15, 48 or 87 cycles) |
| bridge_o | output | 2 | Bridge request: 00 off, 01 drive, 10 fast decay, 11 slow decay |

## Verification
The bench runs off periods with each of the four select codes in mixed mode, so that an error in the lookup or in the fast/slow boundary shows up as a wrong cycle count. One off period follows a non-falling step, to separate the mode latch from the select. Trips are held during off periods and early blanking cycles to show they are ignored, and a trip in the last blanking cycle covers the back-to-back case. Select and mode are changed in the middle of an off period, and enable is dropped in the middle of one, which separates capture-at-trip from live decoding and covers the same-cycle shutdown.

// File: rtl/mixdecay_pkg.sv
package mixdecay_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ON    = 2'd1,
        ST_OFF   = 2'd2,
        ST_BLANK = 2'd3
    } reg_state_e;

    typedef enum logic [1:0] {
        BR_ALLOFF = 2'b00,
        BR_DRIVE  = 2'b01,
        BR_FAST   = 2'b10,
        BR_SLOW   = 2'b11
    } bridge_e;

endpackage

// File: rtl/mixdecay_mode_latch.sv
module mixdecay_mode_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic step_upd_i,
    input  logic step_falls_i,
    output logic mixed_o
);
    typedef struct packed {
        logic mixed;
    } mode_t;

    mode_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_upd_i) begin
            st_d.mixed = step_falls_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mixed <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mixed_o = st_q.mixed;

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step_upd_i |=> $stable(mixed_o)); // R5
endmodule

// File: rtl/mixdecay_fast_len.sv
module mixdecay_fast_len #(
    parameter int CNT_W   = 7,
    parameter int OFF_CYC = 87,
    parameter int FD_LEN0 = 0,
    parameter int FD_LEN1 = 15,
    parameter int FD_LEN2 = 48,
    parameter int FD_LEN3 = 87
) (
    input  logic             mixed_i,
    input  logic [1:0]       sel_i,
    output logic [CNT_W-1:0] len_o
);
    localparam int NSEL = 4;

    logic [CNT_W-1:0] tbl [NSEL];

    for (genvar g = 0; g < NSEL; g++) begin : g_tbl
        localparam int RAW = (g == 0) ? FD_LEN0 : (g == 1) ? FD_LEN1 :
                             (g == 2) ? FD_LEN2 : FD_LEN3;
        localparam int CLIP = (RAW > OFF_CYC) ? OFF_CYC : RAW;
        assign tbl[g] = CNT_W'(CLIP);
    end

    always_comb begin
        if (mixed_i) begin
            len_o = tbl[sel_i];
        end else begin
            len_o = '0;
        end
    end

    always_comb begin
        AST_LEN_RANGE: assert (int'(len_o) <= OFF_CYC); // R4
    end
endmodule

// File: rtl/mixdecay_seq.sv
module mixdecay_seq
    import mixdecay_pkg::*;
#(
    parameter int CNT_W     = 7,
    parameter int OFF_CYC   = 87,
    parameter int BLANK_CYC = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             trip_i,
    input  logic [CNT_W-1:0] flen_i,
    output reg_state_e       state_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] flen_o
);
    localparam logic [CNT_W-1:0] OFF_LAST   = CNT_W'(OFF_CYC - 1);
    localparam logic [CNT_W-1:0] BLANK_LAST = CNT_W'(BLANK_CYC - 1);

    typedef struct packed {
        reg_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] flen;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!en_i) begin
            s_d.state = ST_IDLE;
            s_d.cnt   = '0;
        end else begin
            unique case (s_q.state)
                ST_IDLE: begin
                    s_d.state = ST_ON;
                    s_d.cnt   = '0;
                end
                ST_ON: begin
                    if (trip_i) begin
                        s_d.state = ST_OFF;
                        s_d.cnt   = '0;
                        s_d.flen  = flen_i;
                    end
                end
                ST_OFF: begin
                    if (s_q.cnt == OFF_LAST) begin
                        s_d.state = ST_BLANK;
                        s_d.cnt   = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                ST_BLANK: begin
                    if (s_q.cnt == BLANK_LAST) begin
                        s_d.cnt = '0;
                        if (trip_i) begin
                            s_d.state = ST_OFF;
                            s_d.flen  = flen_i;
                        end else begin
                            s_d.state = ST_ON;
                        end
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                default: begin
                    s_d.state = ST_IDLE;
                    s_d.cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state <= ST_IDLE;
            s_q.cnt   <= '0;
            s_q.flen  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign state_o = s_q.state;
    assign cnt_o   = s_q.cnt;
    assign flen_o  = s_q.flen;

    AST_TRIP_TO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && state_o == ST_ON && trip_i) |=> (state_o == ST_OFF && cnt_o == '0)); // R2
    AST_OFF_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && state_o == ST_OFF && cnt_o == OFF_LAST) |=> (state_o == ST_BLANK || !$past(en_i))); // R3
    AST_OFF_CONT: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && state_o == ST_OFF && cnt_o != OFF_LAST) |=> (state_o == ST_OFF)); // R3
    AST_BLANK_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && state_o == ST_BLANK && cnt_o != BLANK_LAST) |=> (state_o == ST_BLANK)); // R7
    AST_BLANK_RETRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && state_o == ST_BLANK && cnt_o == BLANK_LAST && trip_i) |=> (state_o == ST_OFF)); // R8
    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (state_o == ST_IDLE)); // R9
    AST_FLEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_OFF && $past(state_o) == ST_OFF) |-> $stable(flen_o)); // R10
endmodule

// File: rtl/mixdecay_cur_reg.sv
module mixdecay_cur_reg
    import mixdecay_pkg::*;
#(
    parameter int OFF_CYC   = 87,
    parameter int BLANK_CYC = 6,
    parameter int FD_LEN0   = 0,
    parameter int FD_LEN1   = 15,
    parameter int FD_LEN2   = 48,
    parameter int FD_LEN3   = 87
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable_i,
    input  logic       trip_i,
    input  logic       step_upd_i,
    input  logic       step_falls_i,
    input  logic [1:0] fd_sel_i,
    output logic [1:0] bridge_o
);
    localparam int MAXC  = (OFF_CYC > BLANK_CYC) ? OFF_CYC : BLANK_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);

    logic             mixed;
    logic [CNT_W-1:0] flen_sel;
    logic [CNT_W-1:0] flen_cur;
    logic [CNT_W-1:0] cnt;
    reg_state_e       state;
    bridge_e          br;

    mixdecay_mode_latch u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_upd_i   (step_upd_i),
        .step_falls_i (step_falls_i),
        .mixed_o      (mixed)
    );

    mixdecay_fast_len #(
        .CNT_W   (CNT_W),
        .OFF_CYC (OFF_CYC),
        .FD_LEN0 (FD_LEN0),
        .FD_LEN1 (FD_LEN1),
        .FD_LEN2 (FD_LEN2),
        .FD_LEN3 (FD_LEN3)
    ) u_flen (
        .mixed_i (mixed),
        .sel_i   (fd_sel_i),
        .len_o   (flen_sel)
    );

    mixdecay_seq #(
        .CNT_W     (CNT_W),
        .OFF_CYC   (OFF_CYC),
        .BLANK_CYC (BLANK_CYC)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (enable_i),
        .trip_i  (trip_i),
        .flen_i  (flen_sel),
        .state_o (state),
        .cnt_o   (cnt),
        .flen_o  (flen_cur)
    );

    always_comb begin
        br = BR_ALLOFF;
        if (enable_i) begin
            unique case (state)
                ST_IDLE:  br = BR_ALLOFF;
                ST_ON:    br = BR_DRIVE;
                ST_BLANK: br = BR_DRIVE;
                ST_OFF:   br = (cnt < flen_cur) ? BR_FAST : BR_SLOW;
                default:  br = BR_ALLOFF;
            endcase
        end
    end

    assign bridge_o = br;

    AST_NO_FAST_AFTER_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bridge_o) == BR_SLOW && enable_i) |-> (bridge_o != BR_FAST)); // R4
    AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(enable_i)) |=> (bridge_o == BR_ALLOFF || enable_i)); // R9
endmodule

// File: tb/mixdecay_cur_reg_tb.sv
module mixdecay_cur_reg_tb_top;
    localparam int OFF_N   = 87;
    localparam int BLANK_N = 6;
    localparam logic [1:0] E_OFF   = 2'b00;
    localparam logic [1:0] E_DRIVE = 2'b01;
    localparam logic [1:0] E_FAST  = 2'b10;
    localparam logic [1:0] E_SLOW  = 2'b11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable_i = 1'b0;
    logic trip_i = 1'b0;
    logic step_upd_i = 1'b0;
    logic step_falls_i = 1'b0;
    logic [1:0] fd_sel_i = 2'd0;
    logic [1:0] bridge_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [1:0] ex;
        string      tag;
    } item_t;

    item_t exp_q[$];

    always #5 clk = ~clk;

    mixdecay_cur_reg dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (enable_i),
        .trip_i       (trip_i),
        .step_upd_i   (step_upd_i),
        .step_falls_i (step_falls_i),
        .fd_sel_i     (fd_sel_i),
        .bridge_o     (bridge_o)
    );

    task automatic cyc(input logic en, input logic tr, input logic up, input logic fl,
                       input logic [1:0] sel, input logic [1:0] ex, input string tag);
        item_t it;
        @(negedge clk);
        enable_i     = en;
        trip_i       = tr;
        step_upd_i   = up;
        step_falls_i = fl;
        fd_sel_i     = sel;
        it.ex  = ex;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic off_run(input int nfast, input logic [1:0] sel, input logic tr, input string tag);
        for (int i = 0; i < OFF_N; i++) begin
            cyc(1'b1, tr, 1'b0, 1'b0, sel, (i < nfast) ? E_FAST : E_SLOW, tag);
        end
    endtask

    task automatic blank_run(input logic last_tr, input logic [1:0] sel);
        for (int i = 0; i < BLANK_N; i++) begin
            cyc(1'b1, (i < BLANK_N - 1) ? 1'b1 : last_tr, 1'b0, 1'b0, sel, E_DRIVE, "R7");
        end
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(negedge clk);
            #3;
            while (exp_q.size() > 0) begin
                it = exp_q.pop_front();
                checks++;
                if (bridge_o !== it.ex) begin
                    failures++;
                    $display("FAIL %s bridge actual=%b expected=%b at %0t", it.tag, bridge_o, it.ex, $time);
                end
            end
        end
    end

    initial begin : driver
        // R1: reset holds all-off even with enable high
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, E_OFF, "R1");
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, E_OFF, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        exp_q.push_back('{E_OFF, "R1"});
        // R2: drive phase until trip
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 2'd2, E_DRIVE, "R2");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 2'd2, E_DRIVE, "R2");
        // R6/R4/R10: reset mode is mixed, select 2 captured -> 48 fast; select changed mid-off
        off_run(48, 2'd0, 1'b0, "R10");
        blank_run(1'b0, 2'd0);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, E_DRIVE, "R7");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, E_DRIVE, "R2");
        // R4: select 0 -> pure slow; then R8: retrip at blank end with select 3
        off_run(0, 2'd0, 1'b0, "R4");
        for (int i = 0; i < BLANK_N; i++)
            cyc(1'b1, (i == BLANK_N - 1), 1'b0, 1'b0, 2'd3, E_DRIVE, "R8");
        off_run(OFF_N, 2'd3, 1'b0, "R8");
        blank_run(1'b0, 2'd1);
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 2'd1, E_DRIVE, "R2");
        // R3: trip held high through off period does not shorten it; select 1 -> 15 fast
        off_run(15, 2'd1, 1'b1, "R3");
        blank_run(1'b0, 2'd3);
        // R5: non-falling step selects pure slow even with select 3
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 2'd3, E_DRIVE, "R5");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 2'd3, E_DRIVE, "R5");
        for (int i = 0; i < OFF_N; i++)
            cyc(1'b1, 1'b0, (i == 10), (i == 10), 2'd3, E_SLOW, "R5");
        blank_run(1'b0, 2'd1);
        // R10: falling step latched mid-off applies on the next off period
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 2'd1, E_DRIVE, "R2");
        for (int i = 0; i < 20; i++)
            cyc(1'b1, 1'b0, 1'b0, 1'b0, 2'd1, (i < 15) ? E_FAST : E_SLOW, "R10");
        // R9: drop enable mid-off, then restart
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0, 2'd1, E_OFF, "R9");
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 2'd1, E_OFF, "R9");
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 2'd1, E_DRIVE, "R9");
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 2'd1, E_DRIVE, "R9");
        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired, actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule